// File: doc/BRIEF.md
# Magic Packet Wake Detector

The block watches the byte stream delivered by a receive path, one byte per valid cycle, with markers for the first and the last byte of each frame. It searches every frame for a wake pattern aimed at this station: a run of at least six bytes of value FFh followed at once by sixteen unbroken copies of the programmed 48-bit station address. The pattern may begin at any byte position in the frame. When a frame that holds the pattern ends and is flagged good, a sticky status bit is set.

Software clears the status bit by writing a 1 to it. An active-low wake pin is pulled low while both the status bit and the wake enable are 1. The block also produces a per-frame accept pulse. With the wake enable at 0, this pulse follows the normal receive filter alone. With the enable at 1, a frame is accepted only if it passes both the normal filter and the wake pattern check.

Top module: `wake_frame_detect`

## Requirements
- R1: A frame holding six FFh bytes followed directly by sixteen copies of the station address, with each copy sent most significant byte first (`stn_addr[47:40]` first), sets `wake_sts` in the cycle after the end-of-frame byte, provided `rx_good` is 1 with that byte.
- R2: The pattern is found no matter how many other bytes come before it in the frame.
- R3: A run of more than six FFh bytes ahead of the address copies still counts as a valid synchronisation run.
- R4: A byte that breaks the address copies restarts the search. If that byte is FFh, it counts as the first byte of a new synchronisation run, so a full pattern that starts with it is still detected.
- R5: Fewer than six FFh bytes, or fewer than sixteen address copies, do not set `wake_sts`.
- R6: Detection takes effect only at end of frame, and only when `rx_good` is 1 with the end-of-frame byte. A frame flagged bad does not set `wake_sts`.
- R7: A start of frame clears all match progress, so a pattern split across two frames is not detected.
- R8: `wake_sts` stays set until a cycle with `reg_wr`=1 and `reg_clr`=1. A write with `reg_clr`=0 has no effect. If a detection and a clearing write fall in the same cycle, the detection wins.
- R9: `wake_n` is 0 exactly while `wake_sts` and `wake_en` are both 1. Clearing `wake_en` releases the pin but leaves `wake_sts` unchanged.
- R10: `frame_accept` pulses for one cycle, in the cycle after an end-of-frame byte, when `rx_filt_pass` is 1 and either `wake_en` is 0 or that frame holds the pattern.
- R11: After reset, `wake_sts`=0, `wake_n`=1 and `frame_accept`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Qualifies `rx_data` |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_good | input | 1 | Frame integrity flag, valid with the end-of-frame byte |
| rx_filt_pass | input | 1 | Normal receive filter verdict, valid with the end-of-frame byte |
| stn_addr | input | 48 | Station address, `[47:40]` is sent first |
| wake_en | input | 1 | Wake enable |
| reg_wr | input | 1 | Status register write strobe |
| reg_clr | input | 1 | Write data for the status bit: 1 clears it |
| wake_sts | output | 1 | Sticky wake status |
| wake_n | output | 1 | Wake pin, active low |
| frame_accept | output | 1 | One-cycle accept pulse per frame |

## Verification
The detector is driven with clean patterns at offset zero and after filler bytes. It is also driven with synchronisation runs that are too long and too short, and with address copy counts of fifteen and sixteen. Together these separate correct run counting from off-by-one and restart-instead-of-saturate faults. Further frames break the copies with a non-FFh byte and with an FFh byte that opens a new run, which shows whether the restart credits that byte. Bad frames, patterns split across frames, filter and enable combinations, and clear-versus-set collisions show when detection is committed and how the status bit and the pin interact.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  typedef enum logic { PH_HUNT = 1'b0, PH_COPY = 1'b1 } wfd_phase_e;

  // Byte idx (0 = first on the wire) of an nbytes-wide address held in the low bits.
  function automatic logic [7:0] pick_byte(input logic [63:0] addr,
                                           input int unsigned nbytes,
                                           input int unsigned idx);
    return addr[(nbytes-1-idx)*8 +: 8];
  endfunction

  // Saturating increment toward limit.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned limit);
    return (v >= limit) ? limit : v + 1;
  endfunction
endpackage

// File: rtl/wfd_matcher.sv
module wfd_matcher
  import wfd_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16,
  parameter int ADDR_BYTES = 6
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              rx_data,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic [ADDR_BYTES*8-1:0] stn_addr,
  output logic                    found_nxt
);
  localparam int SYNC_W = $clog2(SYNC_LEN + 1);
  localparam int BYTE_W = $clog2(ADDR_BYTES);
  localparam int COPY_W = $clog2(COPIES);

  typedef struct packed {
    wfd_phase_e          ph;
    logic [SYNC_W-1:0]   sync_cnt;
    logic [BYTE_W-1:0]   bidx;
    logic [COPY_W-1:0]   cidx;
    logic                found;
  } mstate_t;

  mstate_t cur, base, nxt;
  logic [7:0] exp_byte;
  logic       sync_full, last_byte, is_ff;

  always_comb begin
    base = cur;
    if (rx_sof) base = '0;
  end

  assign sync_full = (base.sync_cnt == SYNC_W'(SYNC_LEN));
  assign exp_byte  = pick_byte(64'(stn_addr), ADDR_BYTES,
                               (base.ph == PH_COPY) ? int'(base.bidx) : 0);
  assign last_byte = (base.bidx == BYTE_W'(ADDR_BYTES-1)) && (base.cidx == COPY_W'(COPIES-1));
  assign is_ff     = (rx_data == 8'hFF);

  always_comb begin
    nxt = base;
    if (rx_valid) begin
      if (base.ph == PH_HUNT) begin
        if (sync_full && rx_data == exp_byte) begin
          nxt.ph       = PH_COPY;
          nxt.sync_cnt = '0;
          nxt.bidx     = BYTE_W'(1);
          nxt.cidx     = '0;
        end else if (is_ff) begin
          nxt.sync_cnt = SYNC_W'(sat_inc(int'(base.sync_cnt), SYNC_LEN));
        end else begin
          nxt.sync_cnt = '0;
        end
      end else if (rx_data == exp_byte) begin
        if (last_byte) begin
          nxt.found = 1'b1;
          nxt.ph    = PH_HUNT;
          nxt.bidx  = '0;
          nxt.cidx  = '0;
        end else if (base.bidx == BYTE_W'(ADDR_BYTES-1)) begin
          nxt.bidx = '0;
          nxt.cidx = base.cidx + 1'b1;
        end else begin
          nxt.bidx = base.bidx + 1'b1;
        end
      end else begin
        nxt.ph       = PH_HUNT;
        nxt.bidx     = '0;
        nxt.cidx     = '0;
        nxt.sync_cnt = is_ff ? SYNC_W'(1) : '0;
      end
    end
  end

  assign found_nxt = nxt.found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end
endmodule

// File: rtl/wfd_status.sv
module wfd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_req,
  input  logic wake_en,
  output logic wake_sts,
  output logic wake_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wake_sts <= 1'b0;
    else if (hit)     wake_sts <= 1'b1;
    else if (clr_req) wake_sts <= 1'b0;
  end

  assign wake_n = ~(wake_sts & wake_en);
endmodule

// File: rtl/wake_frame_detect.sv
module wake_frame_detect #(
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16,
  parameter int ADDR_BYTES = 6
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              rx_data,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic                    rx_good,
  input  logic                    rx_filt_pass,
  input  logic [ADDR_BYTES*8-1:0] stn_addr,
  input  logic                    wake_en,
  input  logic                    reg_wr,
  input  logic                    reg_clr,
  output logic                    wake_sts,
  output logic                    wake_n,
  output logic                    frame_accept
);
  logic found_nxt, frame_end, hit, clr_req, accept_nxt;

  wfd_matcher #(.SYNC_LEN(SYNC_LEN), .COPIES(COPIES), .ADDR_BYTES(ADDR_BYTES)) u_match (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .stn_addr(stn_addr), .found_nxt(found_nxt)
  );

  assign frame_end  = rx_valid & rx_eof;
  assign hit        = frame_end & rx_good & found_nxt;
  assign clr_req    = reg_wr & reg_clr;
  assign accept_nxt = frame_end & rx_filt_pass & (~wake_en | found_nxt);

  wfd_status u_sts (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr_req(clr_req),
    .wake_en(wake_en), .wake_sts(wake_sts), .wake_n(wake_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_accept <= 1'b0;
    else        frame_accept <= accept_nxt;
  end
endmodule

// File: rtl/wfd_checker.sv
module wfd_checker (
  input logic clk,
  input logic rst_n,
  input logic hit,
  input logic rx_valid,
  input logic rx_eof,
  input logic rx_good,
  input logic reg_wr,
  input logic reg_clr,
  input logic wake_sts,
  input logic frame_accept
);
  // R1
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n) hit |=> wake_sts);
  // R6
  hit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n) hit |-> (rx_valid && rx_eof && rx_good));
  // R8
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sts && !(reg_wr && reg_clr)) |=> wake_sts);
  // R8
  sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_clr && !hit) |=> !wake_sts);
  // R8
  sts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(wake_sts) |-> $past(hit));
  // R10
  accept_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |-> $past(rx_valid && rx_eof));
endmodule

bind wake_frame_detect wfd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .rx_good(rx_good), .reg_wr(reg_wr), .reg_clr(reg_clr),
  .wake_sts(wake_sts), .frame_accept(frame_accept)
);

// File: tb/wake_frame_detect_test.sv
module wake_frame_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic        rx_good = 1'b0, rx_filt_pass = 1'b0;
  logic [47:0] stn_addr = 48'h1234_5678_9ABC;
  logic        wake_en = 1'b0, reg_wr = 1'b0, reg_clr = 1'b0;
  logic        wake_sts, wake_n, frame_accept;

  int compared = 0, mismatched = 0;
  logic [7:0] q[$];

  always #5 clk = ~clk;

  wake_frame_detect uut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good), .rx_filt_pass(rx_filt_pass),
    .stn_addr(stn_addr), .wake_en(wake_en), .reg_wr(reg_wr), .reg_clr(reg_clr),
    .wake_sts(wake_sts), .wake_n(wake_n), .frame_accept(frame_accept)
  );

  // {pre, ff_len, copies, good, filt, en, exp_sts, exp_acc, 2'b0}
  localparam logic [23:0] VEC [8] = '{
    {8'd0,  4'd6, 5'd16, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b0}, // R1
    {8'd10, 4'd6, 5'd16, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b0}, // R2
    {8'd3,  4'd9, 5'd16, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b0}, // R3
    {8'd2,  4'd5, 5'd16, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b0}, // R5
    {8'd0,  4'd6, 5'd15, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b0}, // R5 R10
    {8'd4,  4'd6, 5'd16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b0}, // R6
    {8'd1,  4'd6, 5'd16, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b0}, // R10
    {8'd7,  4'd7, 5'd16, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b0}  // R10
  };

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic add_fill(input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) q.push_back(v);
  endtask

  task automatic add_copies(input int n);
    for (int c = 0; c < n; c++)
      for (int b = 0; b < 6; b++) q.push_back(stn_addr[47-8*b -: 8]);
  endtask

  // Sends q as one frame; afterwards sits on the negedge after the last byte was clocked.
  task automatic send_frame(input logic good, input logic filt, input logic clr_last);
    for (int i = 0; i < q.size(); i++) begin
      rx_valid = 1'b1; rx_data = q[i];
      rx_sof = (i == 0); rx_eof = (i == q.size() - 1);
      rx_good = good; rx_filt_pass = filt;
      reg_wr = clr_last && (i == q.size() - 1); reg_clr = reg_wr;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; reg_wr = 1'b0; reg_clr = 1'b0;
    q.delete();
  endtask

  task automatic clear_sts();
    reg_wr = 1'b1; reg_clr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 sts", wake_sts, 1'b0);
    check("R11 pin", wake_n, 1'b1);
    check("R11 acc", frame_accept, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      clear_sts();
      wake_en = VEC[v][4];
      add_fill(int'(VEC[v][23:16]), 8'h55);
      add_fill(int'(VEC[v][15:12]), 8'hFF);
      add_copies(int'(VEC[v][11:7]));
      add_fill(2, 8'h00);
      send_frame(VEC[v][6], VEC[v][5], 1'b0);
      check($sformatf("R1/R2/R3/R5/R6 vec%0d sts", v), wake_sts, VEC[v][3]);
      check($sformatf("R10 vec%0d acc", v), frame_accept, VEC[v][2]);
      check($sformatf("R9 vec%0d pin", v), wake_n, ~(VEC[v][3] & VEC[v][4]));
      @(negedge clk);
      check($sformatf("R10 vec%0d acc one cycle", v), frame_accept, 1'b0);
    end

    // R4: break by FFh that opens a new run
    wake_en = 1'b0; clear_sts();
    add_fill(6, 8'hFF); add_copies(3); add_fill(6, 8'hFF); add_copies(16); add_fill(1, 8'h00);
    send_frame(1'b1, 1'b1, 1'b0);
    check("R4 ff restart", wake_sts, 1'b1);

    // R4: break by other byte, remaining copies alone do not count
    clear_sts();
    add_fill(6, 8'hFF); add_copies(5); add_fill(1, 8'h00); add_copies(11); add_fill(1, 8'h00);
    send_frame(1'b1, 1'b1, 1'b0);
    check("R4 broken copies", wake_sts, 1'b0);

    // R7: pattern split across two frames
    clear_sts();
    add_fill(6, 8'hFF); add_copies(8);
    send_frame(1'b1, 1'b1, 1'b0);
    check("R7 first half", wake_sts, 1'b0);
    add_copies(8); add_fill(1, 8'h00);
    send_frame(1'b1, 1'b1, 1'b0);
    check("R7 second half", wake_sts, 1'b0);

    // R8: set wins over simultaneous clear, write 0 ignored, write 1 clears
    add_fill(6, 8'hFF); add_copies(16);
    send_frame(1'b1, 1'b1, 1'b1);
    check("R8 set beats clear", wake_sts, 1'b1);
    reg_wr = 1'b1; reg_clr = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R8 write zero", wake_sts, 1'b1);
    repeat (5) @(negedge clk);
    check("R8 sticky", wake_sts, 1'b1);

    // R9: pin follows enable, status holds
    wake_en = 1'b1; #1;
    check("R9 pin low", wake_n, 1'b0);
    wake_en = 1'b0; @(negedge clk);
    check("R9 pin released", wake_n, 1'b1);
    check("R9 sts held", wake_sts, 1'b1);
    wake_en = 1'b1;
    reg_wr = 1'b1; reg_clr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_clr = 1'b0;
    check("R8 write one clears", wake_sts, 1'b0);
    check("R9 pin after clear", wake_n, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule